// File: doc/BRIEF.md
# Even/Odd Path Merge Butterfly

This block is the closing radix-2 stage of a two-lane parallel pipelined FFT. Upstream, the samples with even and odd indices travel down two independent lanes that never exchange data; they first meet here. Each clock the block may take one complex sample from the even lane and one from the odd lane. Each sample carries its own valid flag. The block pairs the two samples purely by arrival order.

The block has one butterfly and no lane-swapping multiplexers. Each accepted pair produces a sum and a difference, saturated to the sample width. Both results leave together on two output lanes one clock later. A frame marker flags the first pair of every frame. The results leave in bit-reversed bin order, and this block does not reorder them.

If only one lane presents a valid sample in a cycle, the two lanes have lost alignment. The block then drops that sample and raises an error flag for one cycle.

Top module: `pb_merge_stage`

## Requirements
- R1: While reset (`rstN` low) is asserted and in the first cycle after it, `outValid`, `outSof` and `alignErr` are 0, and all four result components are 0.
- R2: When `evenValid` and `oddValid` are both 1 at a rising edge, then after that edge `outValid` is 1 and `sumRe`/`sumIm` equal the two's-complement sums even+odd of the real and imaginary components.
- R3: For the same accepted pair, `diffRe`/`diffIm` equal even minus odd, component by component.
- R4: Each result component is saturated to the signed range of DATA_W bits (-512 to 511 for 10 bits) and never wraps.
- R5: Pairs are combined in arrival order at the rate of one butterfly per clock, with exactly one register stage of latency. The n-th accepted even sample is always matched with the n-th accepted odd sample.
- R6: When exactly one of `evenValid`/`oddValid` is 1 at a rising edge, then after that edge `alignErr` is 1 and `outValid` is 0. The lone sample is dropped: it changes no output and is not counted in the frame.
- R7: `outSof` is 1 together with `outValid` on the first accepted pair after reset and on every FRAME_PAIRS-th accepted pair after that (64 by default). It is 0 on all other cycles.
- R8: Whenever `outValid` is 0, the four result components keep their previous values.
- R9: When neither valid is 1 at an edge, then after that edge both `outValid` and `alignErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| evenValid | input | 1 | Even-lane sample present |
| evenRe | input | 10 | Even-lane real part, signed |
| evenIm | input | 10 | Even-lane imaginary part, signed |
| oddValid | input | 1 | Odd-lane sample present |
| oddRe | input | 10 | Odd-lane real part, signed |
| oddIm | input | 10 | Odd-lane imaginary part, signed |
| outValid | output | 1 | Result pair present |
| outSof | output | 1 | First pair of a frame |
| sumRe | output | 10 | Upper result lane, real: even+odd |
| sumIm | output | 10 | Upper result lane, imaginary |
| diffRe | output | 10 | Lower result lane, real: even-odd |
| diffIm | output | 10 | Lower result lane, imaginary |
| alignErr | output | 1 | Lanes disagreed on valid in the previous cycle |

## Verification
The butterfly is first driven with small mixed-sign pairs, where a swapped operand or a dropped sign extension shows up directly in the difference lane. Extreme pairs then push each component past both saturation limits, separating clamping from wraparound. Lone-lane valids, on the even side and on the odd side, are placed between good pairs to confirm that a dropped sample leaves the data and the frame count untouched. A long run of pseudo-random pairs with occasional misalignments and gaps crosses several frame boundaries to check marker placement against an independently kept pair count.

// File: rtl/pb_pkg.sv
package pb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // accept the current pair into the result registers
    logic sof;    // current pair is the first of a frame
  } ctrlStrobe_t;

  localparam int LANES = 2;  // real and imaginary component lanes
endpackage

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
#(
  parameter int FRAME_PAIRS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evenValid,
  input  logic        oddValid,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        outSof,
  output logic        alignErr
);
  localparam int CNT_W = (FRAME_PAIRS > 1) ? $clog2(FRAME_PAIRS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_PAIRS - 1);

  logic [CNT_W-1:0] pairCnt;
  logic             mismatch;

  // A pair is only taken when both lanes agree
  always_comb begin
    strobe.load = evenValid && oddValid;
    strobe.sof  = strobe.load && (pairCnt == '0);
    mismatch    = evenValid ^ oddValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairCnt  <= '0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      outValid <= strobe.load;
      outSof   <= strobe.sof;
      alignErr <= mismatch;
      if (strobe.load) begin
        pairCnt <= (pairCnt == LAST_IDX) ? '0 : pairCnt + 1'b1;
      end
    end
  end

  assert_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid && oddValid) |=> (outValid && !alignErr));

  assert_mismatch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid != oddValid) |=> (alignErr && !outValid));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!evenValid && !oddValid) |=> (!alignErr && !outValid));

  assert_sof_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  assert_sof_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid != oddValid) |=> $stable(pairCnt));
endmodule

// File: rtl/pb_dpath.sv
module pb_dpath
  import pb_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic signed [DATA_W-1:0] evenRe,
  input  logic signed [DATA_W-1:0] evenIm,
  input  logic signed [DATA_W-1:0] oddRe,
  input  logic signed [DATA_W-1:0] oddIm,
  output logic signed [DATA_W-1:0] sumRe,
  output logic signed [DATA_W-1:0] sumIm,
  output logic signed [DATA_W-1:0] diffRe,
  output logic signed [DATA_W-1:0] diffIm
);
  localparam int EXT_W = DATA_W + 1;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_V = -MAX_V - EXT_W'(1);

  function automatic logic signed [DATA_W-1:0] clampW(input logic signed [EXT_W-1:0] v);
    if (v > MAX_V)      return MAX_V[DATA_W-1:0];
    else if (v < MIN_V) return MIN_V[DATA_W-1:0];
    else                return v[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] evenC [LANES];
  logic signed [DATA_W-1:0] oddC  [LANES];
  logic signed [DATA_W-1:0] sumQ  [LANES];
  logic signed [DATA_W-1:0] diffQ [LANES];

  assign evenC[0] = evenRe;
  assign evenC[1] = evenIm;
  assign oddC[0]  = oddRe;
  assign oddC[1]  = oddIm;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic signed [EXT_W-1:0] evenX, oddX, sumX, diffX;

    always_comb begin
      evenX = {evenC[lane][DATA_W-1], evenC[lane]};
      oddX  = {oddC[lane][DATA_W-1], oddC[lane]};
      sumX  = evenX + oddX;
      diffX = evenX - oddX;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sumQ[lane]  <= '0;
        diffQ[lane] <= '0;
      end else if (strobe.load) begin
        sumQ[lane]  <= clampW(sumX);
        diffQ[lane] <= clampW(diffX);
      end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load |=> ($stable(sumQ[lane]) && $stable(diffQ[lane])));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && !evenC[lane][DATA_W-1] && !oddC[lane][DATA_W-1])
        |=> !sumQ[lane][DATA_W-1]);
  end

  assign sumRe  = sumQ[0];
  assign sumIm  = sumQ[1];
  assign diffRe = diffQ[0];
  assign diffIm = diffQ[1];
endmodule

// File: rtl/pb_merge_stage.sv
module pb_merge_stage
  import pb_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int FRAME_PAIRS = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     evenValid,
  input  logic signed [DATA_W-1:0] evenRe,
  input  logic signed [DATA_W-1:0] evenIm,
  input  logic                     oddValid,
  input  logic signed [DATA_W-1:0] oddRe,
  input  logic signed [DATA_W-1:0] oddIm,
  output logic                     outValid,
  output logic                     outSof,
  output logic signed [DATA_W-1:0] sumRe,
  output logic signed [DATA_W-1:0] sumIm,
  output logic signed [DATA_W-1:0] diffRe,
  output logic signed [DATA_W-1:0] diffIm,
  output logic                     alignErr
);
  ctrlStrobe_t strobe;

  pb_ctrl #(.FRAME_PAIRS(FRAME_PAIRS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evenValid(evenValid), .oddValid(oddValid),
    .strobe(strobe),
    .outValid(outValid), .outSof(outSof), .alignErr(alignErr)
  );

  pb_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evenRe(evenRe), .evenIm(evenIm), .oddRe(oddRe), .oddIm(oddIm),
    .sumRe(sumRe), .sumIm(sumIm), .diffRe(diffRe), .diffIm(diffIm)
  );

  assert_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid && oddValid && evenRe == 0 && evenIm == 0) |=>
      (sumRe == $past(oddRe) && sumIm == $past(oddIm)));

  assert_diff_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid && oddValid && oddRe == 0 && oddIm == 0) |=>
      (diffRe == $past(evenRe) && diffIm == $past(evenIm)));
endmodule

// File: tb/pb_merge_stage_bench.sv
module pb_merge_stage_bench;
  localparam int W = 10;
  localparam int FP = 64;
  localparam int MAXV = 511;
  localparam int MINV = -512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evenValid = 1'b0, oddValid = 1'b0;
  logic signed [W-1:0] evenRe = '0, evenIm = '0, oddRe = '0, oddIm = '0;
  logic outValid, outSof, alignErr;
  logic signed [W-1:0] sumRe, sumIm, diffRe, diffIm;

  int tests = 0;
  int fails = 0;

  // reference model state
  int expValid = 0, expSof = 0, expErr = 0;
  int expSumRe = 0, expSumIm = 0, expDiffRe = 0, expDiffIm = 0;
  int pairCount = 0;
  int satHit = 0;

  always #4 clk = ~clk;

  pb_merge_stage #(.DATA_W(W), .FRAME_PAIRS(FP)) u_pb_merge_stage (
    .clk(clk), .rstN(rstN),
    .evenValid(evenValid), .evenRe(evenRe), .evenIm(evenIm),
    .oddValid(oddValid), .oddRe(oddRe), .oddIm(oddIm),
    .outValid(outValid), .outSof(outSof),
    .sumRe(sumRe), .sumIm(sumIm), .diffRe(diffRe), .diffIm(diffIm),
    .alignErr(alignErr)
  );

  function automatic int clampI(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    string dTag;
    check({tag, " R5/R6 outValid"}, int'(outValid), expValid);
    check({tag, " R7 outSof"}, int'(outSof), expSof);
    check({tag, " R6/R9 alignErr"}, int'(alignErr), expErr);
    if (expValid != 0) dTag = (satHit != 0) ? " R4 sat" : " R2/R3 data";
    else dTag = " R8 hold";
    check({tag, dTag, " sumRe"}, int'(sumRe), expSumRe);
    check({tag, dTag, " sumIm"}, int'(sumIm), expSumIm);
    check({tag, dTag, " diffRe"}, int'(diffRe), expDiffRe);
    check({tag, dTag, " diffIm"}, int'(diffIm), expDiffIm);
  endtask

  // Drive at negedge, step one edge, update model, compare at next negedge
  task automatic step(input string tag, input bit ev, input int er, input int ei,
                      input bit ov, input int orr, input int oi);
    evenValid = ev; evenRe = W'(er); evenIm = W'(ei);
    oddValid = ov; oddRe = W'(orr); oddIm = W'(oi);
    @(posedge clk);
    expErr = (ev != ov) ? 1 : 0;
    expValid = (ev && ov) ? 1 : 0;
    expSof = 0;
    satHit = 0;
    if (ev && ov) begin
      expSof = (pairCount % FP == 0) ? 1 : 0;
      pairCount++;
      expSumRe = clampI(er + orr);
      expSumIm = clampI(ei + oi);
      expDiffRe = clampI(er - orr);
      expDiffIm = clampI(ei - oi);
      if (expSumRe != er + orr || expSumIm != ei + oi ||
          expDiffRe != er - orr || expDiffIm != ei - oi) satHit = 1;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R2 R3: small mixed-sign pairs
    step("R2 pair a", 1, 10, -20, 1, 3, 7);
    step("R3 pair b", 1, -100, 50, 1, 25, -75);
    step("R5 pair c", 1, 0, 0, 1, -1, 1);
    // R9 idle
    step("R9 idle", 0, 99, 99, 0, 99, 99);
    // R4 saturation, both limits
    step("R4 pos", 1, 511, 400, 1, 511, 300);
    step("R4 neg", 1, -512, -400, 1, -512, -300);
    step("R4 diff hi", 1, 511, -512, 1, -512, 511);
    step("R4 diff lo", 1, -512, 0, 1, 511, 0);
    // R6 lone lanes, data must hold (R8)
    step("R6 even only", 1, 5, 5, 0, 1, 1);
    step("R6 odd only", 0, 7, 7, 1, 2, 2);
    step("R5 after err", 1, 1, 2, 1, 3, 4);

    // long run over frame boundaries with faults and gaps (R7)
    for (int i = 0; i < 200; i++) begin
      int k;
      k = int'($urandom_range(0, 15));
      if (k == 0)      step("R6 run even", 1, 1, 1, 0, 0, 0);
      else if (k == 1) step("R6 run odd", 0, 0, 0, 1, 1, 1);
      else if (k == 2) step("R9 run idle", 0, 0, 0, 0, 0, 0);
      else step("R7 run pair",
                1, int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
                1, int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512);
    end
    step("R9 tail", 0, 0, 0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule